// File: doc/BRIEF.md
# Transform Output Dump Controller

This block moves a finished block of transformed samples out of an internal output buffer and onto an output bus. It runs entirely on a free-running output strobe. Its inputs are a dump-hold level and a one-cycle transform-complete pulse from the transform core. The buffer is a simple synchronous memory outside the block. The block drives that memory's read port and passes the returned words through a short register pipeline to the output bus.

When a transform completes, the block first primes its pipeline with a fixed number of strobe edges. It then raises a data-available flag on a strobe edge, with the first sample already waiting on the bus. Each later strobe edge on which hold is low moves one sample, in address order. A downstream stage can use data-available directly as its clock enable. The flag drops on the edge that moves the last sample of the block. A 4-bit scale tag, captured when the transform completes, travels with the data. Data bus and tag are driven only while a sample is actually being offered.

A completion pulse that arrives while a dump is busy is reported as an overrun and otherwise ignored. The one exception is a pulse that lands on the final transfer edge: it starts the next dump at once.

Top module: `xform_dump_ctrl`

## Requirements
- R1: Data-available rises exactly PRIME_EDGES strobe edges after the edge on which a dump starts. A dump starts on the edge that accepts a completion pulse with hold low, or on the first edge that sees hold low after a pulse accepted with hold high. During those edges it stays low.
- R2: If hold is high on the edge that accepts a completion pulse, no read is issued and data-available stays low until an edge samples hold low. Hold has no effect while priming.
- R3: When data-available rises, the bus already carries the sample at address 0 of the new block.
- R4: Each strobe edge with data-available high and hold low moves one sample. After it the bus carries the next address, so samples leave in ascending address order 0 to BLOCK_LEN-1.
- R5: Data-available falls on the edge that moves the sample at address BLOCK_LEN-1, and at no other edge. A block therefore delivers exactly BLOCK_LEN samples.
- R6: While data-available is high, a high hold freezes the output and the read address. No sample is skipped or repeated.
- R7: dout_oe is 1 exactly when data-available is high and hold is low. Whenever dout_oe is 0, dout and scale_tag are high impedance.
- R8: scale_tag shows the value that scale_in had on the edge that accepted the block's completion pulse.
- R9: A completion pulse on any edge other than an idle edge or the final transfer edge raises overrun for the following cycle. It changes neither the running dump nor its data.
- R10: A completion pulse on the final transfer edge, with hold low, is accepted as a new block without overrun, and priming starts on that edge.
- R11: rd_en is high on every priming edge and on every transfer edge until all BLOCK_LEN addresses are read. Reads of one block use addresses 0, 1, 2 and onward, each once. The memory returns data one edge after rd_en and holds its output while rd_en is low.
- R12: During reset, data-available, dout_oe, overrun and rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe_clk | input | 1 | Free-running output strobe; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| dump_hold | input | 1 | High inhibits transfers; sampled at transform end to defer priming |
| xform_done | input | 1 | One-cycle pulse: a transform has finished and the buffer is full |
| scale_in | input | 4 | Scale value of the finished transform |
| rd_data | input | DATA_W | Read data from the synchronous buffer memory |
| rd_en | output | 1 | Buffer read enable |
| rd_addr | output | $clog2(BLOCK_LEN) | Buffer read address |
| dav | output | 1 | Data available; a transfer occurs on each edge with dav high and dump_hold low |
| dout_oe | output | 1 | Output bus drive enable |
| dout | output | DATA_W | Sample output, high impedance when not enabled |
| scale_tag | output | 4 | Scale tag of the block, high impedance when not enabled |
| overrun | output | 1 | One-cycle flag: a completion pulse was rejected |

## Verification
Two events can fall on the same strobe edge: the final transfer of a block and the completion pulse of the next transform. The bench provokes this by raising the completion pulse on roughly half of the cycles where its model expects the last sample to move with hold low. It also injects pulses on ordinary transfer, priming and hold-off cycles, so that accepted and rejected pulses are compared. Such a coincident edge is judged correct when overrun stays low and data-available falls for exactly PRIME_EDGES cycles. The new block must then start at address 0 with the new scale tag, while the last sample of the old block is still delivered intact.

// File: rtl/xdump_pkg.sv
package xdump_pkg;

    typedef enum logic [1:0] {
        DS_IDLE    = 2'd0,
        DS_HOLDOFF = 2'd1,
        DS_PRIME   = 2'd2,
        DS_DUMP    = 2'd3
    } dump_st_e;

endpackage

// File: rtl/xdump_seq.sv
module xdump_seq
    import xdump_pkg::*;
#(
    parameter int BLOCK_LEN   = 1024,
    parameter int PRIME_EDGES = 2,
    parameter int AW          = $clog2(BLOCK_LEN),
    parameter int PCW         = $clog2(PRIME_EDGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          done,
    input  logic [3:0]    scale_in,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          shift,
    output logic          dav,
    output logic [3:0]    scale,
    output logic          overrun
);

    localparam logic [AW:0]    LEN_X      = (AW+1)'(BLOCK_LEN);
    localparam logic [AW-1:0]  LAST_IDX   = AW'(BLOCK_LEN - 1);
    localparam logic [PCW-1:0] PRIME_LAST = PCW'(PRIME_EDGES - 1);

    typedef struct packed {
        dump_st_e       st;
        logic [PCW-1:0] prime;
        logic [AW:0]    addr;
        logic [AW-1:0]  idx;
        logic [3:0]     scale;
        logic           ovr;
    } seq_t;

    seq_t seq_q, seq_d;
    logic shift_c, rd_c, last_c, accept_c;

    always_comb begin
        shift_c  = (seq_q.st == DS_PRIME) || ((seq_q.st == DS_DUMP) && !hold);
        rd_c     = shift_c && (seq_q.addr < LEN_X);
        last_c   = (seq_q.st == DS_DUMP) && !hold && (seq_q.idx == LAST_IDX);
        accept_c = done && ((seq_q.st == DS_IDLE) || last_c);

        seq_d     = seq_q;
        seq_d.ovr = done && !accept_c;
        if (rd_c) begin
            seq_d.addr = seq_q.addr + 1'b1;
        end

        unique case (seq_q.st)
            DS_IDLE: begin
            end
            DS_HOLDOFF: begin
                if (!hold) begin
                    seq_d.st    = DS_PRIME;
                    seq_d.prime = '0;
                    seq_d.addr  = '0;
                end
            end
            DS_PRIME: begin
                seq_d.prime = seq_q.prime + 1'b1;
                if (seq_q.prime == PRIME_LAST) begin
                    seq_d.st  = DS_DUMP;
                    seq_d.idx = '0;
                end
            end
            DS_DUMP: begin
                if (!hold) begin
                    if (last_c) begin
                        seq_d.st = DS_IDLE;
                    end else begin
                        seq_d.idx = seq_q.idx + 1'b1;
                    end
                end
            end
            default: seq_d.st = DS_IDLE;
        endcase

        if (accept_c) begin
            seq_d.scale = scale_in;
            seq_d.prime = '0;
            seq_d.addr  = '0;
            seq_d.st    = hold ? DS_HOLDOFF : DS_PRIME;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: DS_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_en   = rd_c;
    assign rd_addr = seq_q.addr[AW-1:0];
    assign shift   = shift_c;
    assign dav     = (seq_q.st == DS_DUMP);
    assign scale   = seq_q.scale;
    assign overrun = seq_q.ovr;

endmodule

// File: rtl/xdump_pipe.sv
module xdump_pipe #(
    parameter int DATA_W      = 16,
    parameter int PRIME_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] word
);

    // The memory output register is the first stage; these registers follow it.
    localparam int NS = PRIME_EDGES - 1;

    typedef logic [NS-1:0][DATA_W-1:0] stage_t;

    stage_t stg_q, stg_d;

    always_comb begin
        stg_d = stg_q;
        if (adv) begin
            stg_d[0] = rd_data;
            for (int i = 1; i < NS; i++) begin
                stg_d[i] = stg_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign word = stg_q[NS-1];

endmodule

// File: rtl/xdump_pad.sv
module xdump_pad #(
    parameter int DATA_W = 16
) (
    input  logic              oe,
    input  logic [DATA_W-1:0] data,
    input  logic [3:0]        tag,
    output logic [DATA_W-1:0] data_pad,
    output logic [3:0]        tag_pad
);

    assign data_pad = oe ? data : {DATA_W{1'bz}};
    assign tag_pad  = oe ? tag  : 4'bzzzz;

endmodule

// File: rtl/xform_dump_ctrl.sv
module xform_dump_ctrl #(
    parameter int DATA_W      = 16,
    parameter int BLOCK_LEN   = 1024,
    parameter int PRIME_EDGES = 2
) (
    input  logic                         strobe_clk,
    input  logic                         rst_n,
    input  logic                         dump_hold,
    input  logic                         xform_done,
    input  logic [3:0]                   scale_in,
    input  logic [DATA_W-1:0]            rd_data,
    output logic                         rd_en,
    output logic [$clog2(BLOCK_LEN)-1:0] rd_addr,
    output logic                         dav,
    output logic                         dout_oe,
    output logic [DATA_W-1:0]            dout,
    output logic [3:0]                   scale_tag,
    output logic                         overrun
);

    localparam int AW = $clog2(BLOCK_LEN);

    logic              shift_w;
    logic [3:0]        scale_w;
    logic [DATA_W-1:0] word_w;

    xdump_seq #(
        .BLOCK_LEN  (BLOCK_LEN),
        .PRIME_EDGES(PRIME_EDGES),
        .AW         (AW),
        .PCW        ($clog2(PRIME_EDGES))
    ) u_seq (
        .clk     (strobe_clk),
        .rst_n   (rst_n),
        .hold    (dump_hold),
        .done    (xform_done),
        .scale_in(scale_in),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .shift   (shift_w),
        .dav     (dav),
        .scale   (scale_w),
        .overrun (overrun)
    );

    xdump_pipe #(
        .DATA_W     (DATA_W),
        .PRIME_EDGES(PRIME_EDGES)
    ) u_pipe (
        .clk    (strobe_clk),
        .rst_n  (rst_n),
        .adv    (shift_w),
        .rd_data(rd_data),
        .word   (word_w)
    );

    assign dout_oe = dav && !dump_hold;

    xdump_pad #(
        .DATA_W(DATA_W)
    ) u_pad (
        .oe      (dout_oe),
        .data    (word_w),
        .tag     (scale_w),
        .data_pad(dout),
        .tag_pad (scale_tag)
    );

endmodule

// File: rtl/xform_dump_ctrl_chk.sv
module xform_dump_ctrl_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dump_hold,
    input logic          xform_done,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          dav,
    input logic          overrun
);

    AST_RISE_AFTER_PRIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dav) |-> $past(rd_en)); // R1

    AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && (rd_addr != '0)) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R4

    AST_FALL_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav) |-> $past(!dump_hold)); // R5

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (dav && dump_hold) |=> (dav && $stable(rd_addr))); // R6

    AST_OVR_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(xform_done)); // R9

    AST_OVR_KEEPS_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && $past(dav)) |-> dav); // R9

endmodule

bind xform_dump_ctrl xform_dump_ctrl_chk #(
    .AW($clog2(BLOCK_LEN))
) u_chk (
    .clk       (strobe_clk),
    .rst_n     (rst_n),
    .dump_hold (dump_hold),
    .xform_done(xform_done),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .dav       (dav),
    .overrun   (overrun)
);

// File: tb/xform_dump_ctrl_bench.sv
module xform_dump_ctrl_bench;

    localparam int DW = 16;
    localparam int N  = 16;
    localparam int P  = 2;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          hold_i;
    logic          done_i;
    logic [3:0]    scale_i;
    logic [DW-1:0] rd_data;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          dav;
    logic          dout_oe;
    logic [DW-1:0] dout;
    logic [3:0]    scale_tag;
    logic          overrun;

    always #4 clk = ~clk;

    xform_dump_ctrl #(
        .DATA_W(DW), .BLOCK_LEN(N), .PRIME_EDGES(P)
    ) u_xform_dump_ctrl (
        .strobe_clk(clk), .rst_n(rst_n), .dump_hold(hold_i), .xform_done(done_i),
        .scale_in(scale_i), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .dav(dav), .dout_oe(dout_oe), .dout(dout), .scale_tag(scale_tag),
        .overrun(overrun)
    );

    // Synchronous buffer: one-edge latency, output held while not enabled (R11).
    logic [DW-1:0] bmem [N];
    logic [DW-1:0] mem_q;
    always_ff @(posedge clk) if (rd_en) mem_q <= bmem[rd_addr];
    assign rd_data = mem_q;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    function automatic logic [DW-1:0] word_of(int blk, int a);
        return DW'((blk * 40503) ^ (a * 257) ^ 32'h3C1);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Bench model: 0 idle, 1 hold-off, 2 priming, 3 dumping
    int m_st = 0, m_cnt = 0, m_k = 0, m_iss = 0, m_blk = 0, m_scale = 0;
    bit m_ovr = 1'b0, m_b2b_prev = 1'b0;
    int n_b2b = 0, n_ovr = 0, n_hoff = 0, n_pause = 0;

    initial begin
        int gap;
        bit exp_dav, exp_oe, exp_rd, acc, b2b;
        void'($urandom(32'd7719));
        rst_n = 1'b0; hold_i = 1'b0; done_i = 1'b0; scale_i = '0;
        for (int a = 0; a < N; a++) bmem[a] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(dav == 1'b0, "R12", "dav in reset", int'(dav), 0);
        chk(dout_oe == 1'b0, "R12", "dout_oe in reset", int'(dout_oe), 0);
        chk(overrun == 1'b0, "R12", "overrun in reset", int'(overrun), 0);
        chk(rd_en == 1'b0, "R12", "rd_en in reset", int'(rd_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        gap = 2;

        for (int cyc = 0; cyc < 20000; cyc++) begin
            if (m_blk >= 40 && m_st == 0) break;
            @(negedge clk);
            done_i = 1'b0;
            scale_i = 4'($urandom % 16);
            case (m_st)
                0: begin
                    hold_i = ($urandom % 4 == 0);
                    if (m_blk < 40) begin
                        if (gap == 0) begin
                            done_i = 1'b1;
                            gap = int'($urandom % 5);
                        end else gap--;
                    end
                end
                1: begin
                    hold_i = ($urandom % 3 != 0);
                    done_i = ($urandom % 10 == 0);
                end
                2: begin
                    hold_i = ($urandom % 2 == 0);
                    done_i = ($urandom % 10 == 0);
                end
                default: begin
                    hold_i = ($urandom % 4 == 0);
                    if (m_k == N-1 && !hold_i) done_i = ($urandom % 2 == 0) && (m_blk < 40);
                    else done_i = ($urandom % 20 == 0);
                end
            endcase
            #1;
            // Compare outputs against model state
            exp_dav = (m_st == 3);
            chk(dav == exp_dav,
                (m_st == 3) ? ((m_k == 0) ? "R1" : "R5") : ((m_st == 1) ? "R2" : ((m_st == 2) ? "R1" : "R5")),
                "dav", int'(dav), int'(exp_dav));
            exp_oe = exp_dav && !hold_i;
            chk(dout_oe == exp_oe, (exp_dav && hold_i) ? "R6" : "R7", "dout_oe", int'(dout_oe), int'(exp_oe));
            if (exp_oe && dout_oe) begin
                chk(dout == word_of(m_blk, m_k), (m_k == 0) ? "R3" : "R4", "dout",
                    int'(dout), int'(word_of(m_blk, m_k)));
                chk(scale_tag == 4'(m_scale), "R8", "scale_tag", int'(scale_tag), m_scale);
            end
            exp_rd = (m_st == 2) || (m_st == 3 && !hold_i && m_iss < N);
            chk(rd_en == exp_rd, "R11", "rd_en", int'(rd_en), int'(exp_rd));
            if (exp_rd && rd_en) chk(int'(rd_addr) == m_iss, "R11", "rd_addr", int'(rd_addr), m_iss);
            chk(overrun == m_ovr, m_b2b_prev ? "R10" : "R9", "overrun", int'(overrun), int'(m_ovr));

            // Advance the model across the coming edge
            acc = done_i && (m_st == 0 || (m_st == 3 && !hold_i && m_k == N-1));
            b2b = acc && (m_st == 3);
            m_ovr = done_i && !acc;
            if (m_ovr) n_ovr++;
            m_b2b_prev = b2b;
            if (b2b) n_b2b++;
            if (m_st == 3 && hold_i) n_pause++;
            if (exp_rd) m_iss++;
            case (m_st)
                1: if (!hold_i) begin m_st = 2; m_cnt = 0; m_iss = 0; end
                2: begin
                    m_cnt++;
                    if (m_cnt == P) begin m_st = 3; m_k = 0; end
                end
                3: if (!hold_i) begin
                    if (m_k == N-1) m_st = 0;
                    else m_k++;
                end
                default: ;
            endcase
            if (acc) begin
                m_blk++;
                for (int a = 0; a < N; a++) bmem[a] = word_of(m_blk, a);
                m_scale = int'(scale_i);
                m_st = hold_i ? 1 : 2;
                m_cnt = 0;
                m_iss = 0;
                if (hold_i) n_hoff++;
            end
        end

        chk(m_st == 0, "R5", "dump finished", m_st, 0);
        chk(n_b2b > 0, "R10", "coincident final edge and pulse seen", n_b2b, 1);
        chk(n_ovr > 0, "R9", "overrun case seen", n_ovr, 1);
        chk(n_hoff > 0, "R2", "hold at transform end seen", n_hoff, 1);
        chk(n_pause > 0, "R6", "paused transfer seen", n_pause, 1);
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule